// File: doc/BRIEF.md
# Armed Start Trigger for Converter Data

This block decides when application samples begin moving toward the serial link, and it issues the reset strobe that restarts the tone and pseudo-random pattern generators. Software arms the trigger by writing a 1 to a self-clearing control bit. While the trigger is armed, the per-channel valid qualifiers sent to the application are held low and an armed status flag reads 1. The next rising edge of the external sync input, which is already synchronous to the converter clock, releases the valid qualifiers, clears the status flag and emits a one-cycle generator reset.

A build parameter removes the external trigger. In that build the sync input is ignored and the trigger never arms. An arm write then produces only the generator reset strobe, and valid stays high.

The control is a three-state machine. In RUN, data flows. A qualifying arm write moves it from RUN to ARMED. In ARMED, valid is gated, and a sync rising edge moves it to FIRE; without an edge it stays in ARMED. FIRE lasts one cycle and drives the generator reset. From FIRE it returns to RUN, or goes to ARMED if another arm write arrives in that cycle. When the external trigger is disabled, an arm write in RUN or FIRE leads to FIRE. Otherwise the machine returns to RUN.

Top module: `sync_start_gate`

## Requirements
- R1: While reset (rst_n low) is sampled, and in the cycle after it, armed_status, gen_reset and arm_bit_rd are 0 and every bit of dac_valid is 1.
- R2: With EXT_SYNC=1, a clock edge that samples arm_wr_en=1 and arm_wr_bit=1 while not armed sets armed_status to 1 and drives every dac_valid bit to 0 from the next cycle on.
- R3: arm_bit_rd is 1 for exactly the one cycle after an edge that samples arm_wr_en=1 with arm_wr_bit=1, and 0 otherwise.
- R4: With EXT_SYNC=1, while armed, an edge that samples sync_in=1 after sync_in=0 on the previous edge makes the next cycle show armed_status=0, all dac_valid bits 1, and gen_reset=1.
- R5: While armed, sync_in held at 1, held at 0 or falling leaves the block armed, with valid low and no reset pulse.
- R6: A sync rising edge sampled on the same edge as the arm write is not counted: the block is armed afterwards.
- R7: An arm write while already armed leaves the block armed, with no reset pulse.
- R8: An arm write sampled on the same edge as a rising edge, while armed, does not prevent the trigger from firing.
- R9: While not armed, sync_in activity has no effect: valid stays 1 and gen_reset stays 0.
- R10: With EXT_SYNC=0, armed_status is always 0, dac_valid is always all 1, sync_in is ignored, and every arm write yields gen_reset=1 in the following cycle.
- R11: With EXT_SYNC=1, gen_reset is never 1 in two consecutive cycles.
- R12: A write with arm_wr_bit=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_wr_en | input | 1 | Control register write strobe |
| arm_wr_bit | input | 1 | Written value of the arm bit (1 = arm) |
| sync_in | input | 1 | External sync, synchronous to clk |
| arm_bit_rd | output | 1 | Read-back value of the self-clearing arm bit |
| armed_status | output | 1 | 1 while waiting for the sync edge |
| gen_reset | output | 1 | One-cycle reset strobe for pattern generators |
| dac_valid | output | NUM_CH | Per-channel valid toward the application |

## Verification
The bench aims at the edge-timing corners. A sync edge that coincides with the arm write is one of them: a design that compared against a stale or unreset copy of the input would fire at once and never gate valid. Holding sync high across the arm, then letting it fall, catches a level-sensitive trigger, which would release data with no edge. A repeated arm write while armed, and an arm write on the same edge as the trigger, expose a priority fault, which would either emit a spurious reset or stay stuck armed. The instance built without the external trigger is driven with the same stimulus, and a design that let sync_in through or armed that instance would show gated valid there.

// File: rtl/sync_trig_pkg.sv
package sync_trig_pkg;

    // RUN: data flows; ARMED: waiting for a sync edge; FIRE: one-cycle generator reset
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } trig_state_e;

endpackage

// File: rtl/sync_rise_det.sv
module sync_rise_det #(
    parameter bit USE_EXT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise_o
);

    generate
        if (USE_EXT) begin : g_ext
            logic sync_q;

            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= 1'b0;
                else        sync_q <= sync_in;
            end

            assign rise_o = sync_in & ~sync_q;
        end else begin : g_no_ext
            assign rise_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sync_arm_reg.sv
module sync_arm_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic arm_req_o,
    output logic arm_rd_o
);

    logic arm_q;

    assign arm_req_o = wr_en & wr_bit;

    // self-clearing: holds the written 1 for a single cycle
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm_req_o;
    end

    assign arm_rd_o = arm_q;

endmodule

// File: rtl/sync_trig_fsm.sv
module sync_trig_fsm
    import sync_trig_pkg::*;
#(
    parameter bit USE_EXT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic rise,
    output logic armed_o,
    output logic fire_o
);

    trig_state_e state_q;
    trig_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_FIRE: begin
                if (arm_req) state_d = USE_EXT ? ST_ARMED : ST_FIRE;
                else         state_d = ST_RUN;
            end
            ST_ARMED: begin
                if (rise) state_d = ST_FIRE;
                else      state_d = ST_ARMED;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        armed_o = 1'b0;
        fire_o  = 1'b0;
        unique case (state_q)
            ST_RUN:   ;
            ST_ARMED: armed_o = 1'b1;
            ST_FIRE:  fire_o  = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/sync_start_gate.sv
module sync_start_gate #(
    parameter int NUM_CH   = 4,
    parameter bit EXT_SYNC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_wr_en,
    input  logic              arm_wr_bit,
    input  logic              sync_in,
    output logic              arm_bit_rd,
    output logic              armed_status,
    output logic              gen_reset,
    output logic [NUM_CH-1:0] dac_valid
);

    logic arm_req;
    logic rise;
    logic armed;
    logic fire;

    sync_arm_reg u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (arm_wr_en),
        .wr_bit    (arm_wr_bit),
        .arm_req_o (arm_req),
        .arm_rd_o  (arm_bit_rd)
    );

    sync_rise_det #(.USE_EXT(EXT_SYNC)) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .rise_o  (rise)
    );

    sync_trig_fsm #(.USE_EXT(EXT_SYNC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_req (arm_req),
        .rise    (rise),
        .armed_o (armed),
        .fire_o  (fire)
    );

    assign armed_status = armed;
    assign gen_reset    = fire;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_valid
            assign dac_valid[ch] = ~armed;
        end
    endgenerate

endmodule

// File: rtl/sync_start_gate_chk.sv
module sync_start_gate_chk #(
    parameter int NUM_CH   = 4,
    parameter bit EXT_SYNC = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_wr_en,
    input logic              arm_wr_bit,
    input logic              sync_in,
    input logic              arm_bit_rd,
    input logic              armed_status,
    input logic              gen_reset,
    input logic [NUM_CH-1:0] dac_valid
);

    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_status |-> (dac_valid == '0));

    assert_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_status |-> (dac_valid == '1));

    assert_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(arm_wr_en && arm_wr_bit) |=> !arm_bit_rd);

    assert_setbit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr_en && arm_wr_bit) |=> arm_bit_rd);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_status && !(arm_wr_en && arm_wr_bit)) |=> (!gen_reset && !armed_status));

    generate
        if (EXT_SYNC) begin : g_ext
            assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (arm_wr_en && arm_wr_bit && !armed_status) |=> armed_status);

            assert_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_status && $rose(sync_in)) |=> (gen_reset && !armed_status));

            assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (armed_status && !$rose(sync_in)) |=> (armed_status && !gen_reset));

            assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
                gen_reset |=> !gen_reset);
        end else begin : g_no_ext
            assert_never_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !armed_status);

            assert_sw_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (arm_wr_en && arm_wr_bit) |=> gen_reset);
        end
    endgenerate

endmodule

bind sync_start_gate sync_start_gate_chk #(
    .NUM_CH   (NUM_CH),
    .EXT_SYNC (EXT_SYNC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_wr_en    (arm_wr_en),
    .arm_wr_bit   (arm_wr_bit),
    .sync_in      (sync_in),
    .arm_bit_rd   (arm_bit_rd),
    .armed_status (armed_status),
    .gen_reset    (gen_reset),
    .dac_valid    (dac_valid)
);

// File: tb/test_sync_start_gate.sv
module test_sync_start_gate;

    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm_wr_en = 1'b0;
    logic arm_wr_bit = 1'b0;
    logic sync_in = 1'b0;

    logic           rd1, st1, gr1;
    logic [NCH-1:0] v1;
    logic           rd0, st0, gr0;
    logic [NCH-1:0] v0;

    int    vectors = 0;
    int    errors = 0;
    bit    seen = 1'b0;
    bit    done = 1'b0;
    string phase = "R1";

    // behavioural model: 0 = flowing, 1 = waiting, 2 = strobe
    int m_ext = 0;
    int m_sw = 0;
    bit m_bit = 1'b0;
    bit m_prev = 1'b0;

    always #10 clk = ~clk;

    sync_start_gate #(.NUM_CH(NCH), .EXT_SYNC(1'b1)) i_sync_start_gate (
        .clk(clk), .rst_n(rst_n), .arm_wr_en(arm_wr_en), .arm_wr_bit(arm_wr_bit),
        .sync_in(sync_in), .arm_bit_rd(rd1), .armed_status(st1),
        .gen_reset(gr1), .dac_valid(v1)
    );

    sync_start_gate #(.NUM_CH(NCH), .EXT_SYNC(1'b0)) i_sync_start_gate_nosync (
        .clk(clk), .rst_n(rst_n), .arm_wr_en(arm_wr_en), .arm_wr_bit(arm_wr_bit),
        .sync_in(sync_in), .arm_bit_rd(rd0), .armed_status(st0),
        .gen_reset(gr0), .dac_valid(v0)
    );

    always @(posedge clk) begin
        bit req;
        bit edge_seen;
        if (!rst_n) begin
            m_ext = 0; m_sw = 0; m_bit = 1'b0; m_prev = 1'b0;
        end else begin
            req = arm_wr_en && arm_wr_bit;
            edge_seen = sync_in && !m_prev;
            if (m_ext == 1) m_ext = edge_seen ? 2 : 1;
            else            m_ext = req ? 1 : 0;
            m_sw   = req ? 2 : 0;
            m_bit  = req;
            m_prev = sync_in;
        end
        seen = 1'b1;
    end

    task automatic check(input string tag, input string what, input logic [NCH-1:0] act,
                         input logic [NCH-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (seen && !done) begin
            check(phase, "ext armed_status", NCH'(st1), NCH'(m_ext == 1));
            check(phase, "ext gen_reset", NCH'(gr1), NCH'(m_ext == 2));
            check(phase, "ext dac_valid", v1, (m_ext == 1) ? '0 : '1);
            check("R3", "ext arm_bit_rd", NCH'(rd1), NCH'(m_bit));
            check("R10", "nosync armed_status", NCH'(st0), '0);
            check("R10", "nosync gen_reset", NCH'(gr0), NCH'(m_sw == 2));
            check("R10", "nosync dac_valid", v0, '1);
            check("R3", "nosync arm_bit_rd", NCH'(rd0), NCH'(m_bit));
        end
    end

    task automatic drive(input bit w, input bit b, input bit s, input int n);
        arm_wr_en = w; arm_wr_bit = b; sync_in = s;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        phase = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 0, 2);
        phase = "R9";
        drive(0, 0, 1, 2); drive(0, 0, 0, 1); drive(0, 0, 1, 1); drive(0, 0, 0, 2);
        phase = "R12";
        drive(1, 0, 0, 1); drive(1, 0, 1, 1); drive(0, 0, 0, 2);
        phase = "R2";
        drive(1, 1, 0, 1); drive(0, 0, 0, 3);
        phase = "R4";
        drive(0, 0, 1, 1); drive(0, 0, 1, 1); drive(0, 0, 0, 2);
        phase = "R6";
        drive(1, 1, 1, 1);
        phase = "R5";
        drive(0, 0, 1, 3); drive(0, 0, 0, 3);
        phase = "R7";
        drive(1, 1, 0, 1); drive(0, 0, 0, 1); drive(1, 1, 0, 2); drive(0, 0, 0, 2);
        phase = "R8";
        drive(1, 1, 1, 1); drive(0, 0, 0, 3);
        phase = "R11";
        drive(1, 1, 0, 1); drive(0, 0, 1, 1); drive(1, 1, 0, 1); drive(0, 0, 1, 1);
        drive(0, 0, 0, 3);
        phase = "R10";
        drive(1, 1, 1, 1); drive(1, 1, 0, 1); drive(0, 0, 1, 2);
        phase = "R1";
        rst_n = 1'b0;
        drive(1, 1, 1, 2);
        rst_n = 1'b1;
        drive(0, 0, 0, 3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule